// File: doc/BRIEF.md
# Token-Strobed Dual-Edge Column Loader

This block fills a row of per-channel pixel-code registers from one shared 7-bit parallel bus. A select token enters the block and walks through the channels. Every transition of the shift clock, rising or falling, stores the word on the bus into the channel the token has reached. A full row therefore takes half as many shift-clock periods as there are channels. The row registers only change during a fill, so a later conversion stage can use the previous row while a new one is loaded.

A direction strap sets the fill order, ascending or descending. It also decides which of the two bidirectional select pins receives the token and which one drives it on. After the last channel in the fill order is stored, the block sends a half-shift-clock-period pulse on its exit pin. The next device in the chain then starts filling on its next rising shift-clock edge.

All logic runs on one free-running system clock. The shift clock, the select pins and the bus are sampled with that clock, and shift-clock transitions are found by comparing consecutive samples. For this to work, each shift-clock level must last at least two system clocks, and bus data must be steady in the sample taken with the edge.

Top module: `token_column_loader`

## Requirements
- R1: While reset is high and after its release, every channel code is 0 and both select outputs drive 0.
- R2: When the block is idle, a rising shift-clock edge seen while the entry select pin is high stores the bus word into the first channel in fill order. That channel is channel 0 when ascending and channel 31 when descending.
- R3: Each later shift-clock edge of either polarity stores the next bus word into the next channel in fill order. The 32 words are stored in 16 shift-clock periods, and at most one channel changes per system clock.
- R4: With the direction strap high, channels fill from 0 to 31. Pin A is the entry (A output-enable 0) and pin B is the exit (B output-enable 1).
- R5: With the direction strap low, channels fill from 31 to 0. Pin B is the entry (B output-enable 0) and pin A is the exit (A output-enable 1). A pin whose output-enable is 0 always drives 0.
- R6: The exit pin goes high with the edge that stores the last channel and goes low at the next shift-clock edge. At no other time is it high.
- R7: A high entry pin is ignored on a falling edge while idle, and ignored at any edge during a fill or while the exit pulse is out.
- R8: Once the exit pulse is out, further shift-clock edges leave all codes unchanged until a new token starts a fill.
- R9: When the exit of one block feeds the entry of a second block, the second block stores the bus words that follow the first block's last word, in its own fill order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, at least 4x the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Shift clock; both transitions store a word |
| dir_asc | input | 1 | Direction strap: 1 ascending, 0 descending |
| bus_code | input | 7 | Shared pixel-code bus |
| tok_a_in | input | 1 | Select pin A, receive side |
| tok_a_out | output | 1 | Select pin A, drive side |
| tok_a_oe | output | 1 | Select pin A output enable |
| tok_b_in | input | 1 | Select pin B, receive side |
| tok_b_out | output | 1 | Select pin B, drive side |
| tok_b_oe | output | 1 | Select pin B output enable |
| codes_flat | output | 224 | Channel k code at bits [7k+6:7k] |

## Verification
Both directions are swept with several arithmetic word patterns, including an alternating all-zeros/all-ones pattern. These separate a correct channel order from a reversed one, and show any bit-lane mixing. One run raises the token again in the middle of a fill, which shows whether a second token restarts the fill. Extra edges after the exit pulse, including a falling edge with the token high, show whether anything is stored after the fill ends. A chained pair of blocks fed one 64-word stream shows that the handoff lands on exactly the next word in both directions.

// File: rtl/colload_pkg.sv
package colload_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PASS = 2'd2
    } fill_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic tok_entry;
    } edge_evt_t;

    function automatic int unsigned chan_of(input int unsigned step,
                                            input logic asc,
                                            input int unsigned last);
        return asc ? step : (last - step);
    endfunction

endpackage

// File: rtl/colload_sampler.sv
module colload_sampler
    import colload_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              dir_asc,
    input  logic              tok_a_in,
    input  logic              tok_b_in,
    input  logic [CODE_W-1:0] bus_code,
    output edge_evt_t         evt,
    output logic              dir_q,
    output logic [CODE_W-1:0] bus_q
);
    logic sclk_q, sclk_p, ta_q, tb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sclk_p <= 1'b0;
            ta_q   <= 1'b0;
            tb_q   <= 1'b0;
            dir_q  <= 1'b0;
            bus_q  <= '0;
        end else begin
            sclk_q <= sclk_in;
            sclk_p <= sclk_q;
            ta_q   <= tok_a_in;
            tb_q   <= tok_b_in;
            dir_q  <= dir_asc;
            bus_q  <= bus_code;
        end
    end

    // transitions found by comparing two consecutive samples
    always_comb begin
        evt.rise      = sclk_q & ~sclk_p;
        evt.fall      = ~sclk_q & sclk_p;
        evt.tok_entry = dir_q ? ta_q : tb_q;
    end
endmodule

// File: rtl/colload_seq.sv
module colload_seq
    import colload_pkg::*;
#(
    parameter int CHANNELS = 32,
    localparam int CH_W = $clog2(CHANNELS)
) (
    input  logic            clk,
    input  logic            rst,
    input  edge_evt_t       evt,
    input  logic            dir_q,
    output logic            cap_en,
    output logic [CH_W-1:0] cap_ch,
    output logic            exit_pulse
);
    localparam int unsigned LAST = CHANNELS - 1;

    fill_state_t     state;
    logic [CH_W-1:0] step;
    logic [CH_W-1:0] cap_step;
    logic            any_edge;

    assign any_edge = evt.rise | evt.fall;

    always_comb begin
        cap_en   = 1'b0;
        cap_step = step;
        unique case (state)
            ST_IDLE: begin
                if (evt.rise && evt.tok_entry) begin
                    cap_en   = 1'b1;
                    cap_step = '0;
                end
            end
            ST_FILL: cap_en = any_edge;
            default: cap_en = 1'b0;
        endcase
    end

    assign cap_ch = CH_W'(chan_of(32'(cap_step), dir_q, LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            step       <= '0;
            exit_pulse <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (evt.rise && evt.tok_entry) begin
                        step  <= CH_W'(1);
                        state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (any_edge) begin
                        if (step == CH_W'(LAST)) begin
                            state      <= ST_PASS;
                            exit_pulse <= 1'b1;
                        end else begin
                            step <= step + CH_W'(1);
                        end
                    end
                end
                default: begin
                    if (any_edge) begin
                        exit_pulse <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/colload_bank.sv
module colload_bank #(
    parameter int CHANNELS = 32,
    parameter int CODE_W   = 7,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_en,
    input  logic [CH_W-1:0]            cap_ch,
    input  logic [CODE_W-1:0]          bus_q,
    output logic [CHANNELS*CODE_W-1:0] codes_flat
);
    for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
        logic [CODE_W-1:0] code_r;
        always_ff @(posedge clk) begin
            if (rst)
                code_r <= '0;
            else if (cap_en && cap_ch == CH_W'(k))
                code_r <= bus_q;
        end
        assign codes_flat[k*CODE_W +: CODE_W] = code_r;
    end
endmodule

// File: rtl/token_column_loader.sv
module token_column_loader
    import colload_pkg::*;
#(
    parameter int CHANNELS = 32,
    parameter int CODE_W   = 7,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk_in,
    input  logic                       dir_asc,
    input  logic [CODE_W-1:0]          bus_code,
    input  logic                       tok_a_in,
    output logic                       tok_a_out,
    output logic                       tok_a_oe,
    input  logic                       tok_b_in,
    output logic                       tok_b_out,
    output logic                       tok_b_oe,
    output logic [CHANNELS*CODE_W-1:0] codes_flat
);
    edge_evt_t         evt;
    logic              dir_q;
    logic [CODE_W-1:0] bus_q;
    logic              cap_en;
    logic [CH_W-1:0]   cap_ch;
    logic              exit_pulse;

    colload_sampler #(.CODE_W(CODE_W)) u_smp (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .dir_asc(dir_asc),
        .tok_a_in(tok_a_in), .tok_b_in(tok_b_in), .bus_code(bus_code),
        .evt(evt), .dir_q(dir_q), .bus_q(bus_q)
    );

    colload_seq #(.CHANNELS(CHANNELS)) u_seq (
        .clk(clk), .rst(rst), .evt(evt), .dir_q(dir_q),
        .cap_en(cap_en), .cap_ch(cap_ch), .exit_pulse(exit_pulse)
    );

    colload_bank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_ch(cap_ch),
        .bus_q(bus_q), .codes_flat(codes_flat)
    );

    // ascending: A receives, B drives; descending: roles swap
    assign tok_a_oe  = ~dir_q;
    assign tok_b_oe  = dir_q;
    assign tok_a_out = ~dir_q & exit_pulse;
    assign tok_b_out = dir_q & exit_pulse;
endmodule

// File: rtl/colload_chk.sv
module colload_chk #(
    parameter int CHANNELS = 32,
    parameter int CODE_W   = 7
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       dir_asc,
    input logic                       tok_a_out,
    input logic                       tok_a_oe,
    input logic                       tok_b_out,
    input logic                       tok_b_oe,
    input logic [CHANNELS*CODE_W-1:0] codes_flat
);
    logic [CHANNELS*CODE_W-1:0] prev_codes;
    logic [CHANNELS-1:0]        chg;
    logic                       exit_any;

    always_ff @(posedge clk) prev_codes <= codes_flat;

    for (genvar k = 0; k < CHANNELS; k++) begin : g_chg
        assign chg[k] = codes_flat[k*CODE_W +: CODE_W] != prev_codes[k*CODE_W +: CODE_W];
    end

    assign exit_any = tok_a_out | tok_b_out;

    assert_exit_follows_strap_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tok_b_oe == $past(dir_asc)));

    assert_quiet_a_R5: assert property (@(posedge clk) disable iff (rst)
        !tok_a_oe |-> !tok_a_out);

    assert_quiet_b_R5: assert property (@(posedge clk) disable iff (rst)
        !tok_b_oe |-> !tok_b_out);

    assert_one_channel_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(chg) <= 1);

    assert_hold_in_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (exit_any && $past(exit_any)) |-> (chg == '0));
endmodule

bind token_column_loader colload_chk #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .dir_asc(dir_asc),
    .tok_a_out(tok_a_out), .tok_a_oe(tok_a_oe),
    .tok_b_out(tok_b_out), .tok_b_oe(tok_b_oe),
    .codes_flat(codes_flat)
);

// File: tb/sim_token_column_loader.sv
`timescale 1ns/1ps
module sim_token_column_loader;
    localparam int CH = 32;
    localparam int W  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic dir_asc = 1'b1;
    logic [W-1:0] bus = '0;
    logic ent = 1'b0;
    logic chain_en = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [W-1:0] words [0:63];

    logic u0_ta_out, u0_ta_oe, u0_tb_out, u0_tb_oe;
    logic u1_ta_out, u1_ta_oe, u1_tb_out, u1_tb_oe;
    logic [CH*W-1:0] c0, c1;
    logic u0_ta_in, u0_tb_in, u1_ta_in, u1_tb_in;

    always #2.5 clk = ~clk;

    assign u0_ta_in = dir_asc & ent;
    assign u0_tb_in = ~dir_asc & ent;
    assign u1_ta_in = chain_en & dir_asc & u0_tb_out;
    assign u1_tb_in = chain_en & ~dir_asc & u0_ta_out;

    token_column_loader u0 (
        .clk(clk), .rst(rst), .sclk_in(sclk), .dir_asc(dir_asc), .bus_code(bus),
        .tok_a_in(u0_ta_in), .tok_a_out(u0_ta_out), .tok_a_oe(u0_ta_oe),
        .tok_b_in(u0_tb_in), .tok_b_out(u0_tb_out), .tok_b_oe(u0_tb_oe),
        .codes_flat(c0)
    );

    token_column_loader u1 (
        .clk(clk), .rst(rst), .sclk_in(sclk), .dir_asc(dir_asc), .bus_code(bus),
        .tok_a_in(u1_ta_in), .tok_a_out(u1_ta_out), .tok_a_oe(u1_ta_oe),
        .tok_b_in(u1_tb_in), .tok_b_out(u1_tb_out), .tok_b_oe(u1_tb_oe),
        .codes_flat(c1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_one(input logic [W-1:0] w);
        bus = w;
        repeat (2) @(negedge clk);
        sclk = ~sclk;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [W-1:0] gen(input int i, input int seed);
        if (seed == 0) return (i % 2) ? 7'h7f : 7'h00;
        return W'((i * seed + 5 * seed) % 128);
    endfunction

    task automatic cmp_row(input logic [CH*W-1:0] row, input int base, input string tag);
        for (int k = 0; k < CH; k++) begin
            int st = dir_asc ? k : CH - 1 - k;
            int act = int'(row[k*W +: W]);
            int exp = int'(words[base + st]);
            chk(act == exp, (st == 0 && tag == "R3") ? "R2" : tag, act, exp);
        end
    endtask

    task automatic fill_run(input logic d, input int seed, input bit mid_tok, input bit chain);
        int n = chain ? 64 : 32;
        dir_asc = d;
        chain_en = chain;
        repeat (3) @(negedge clk);
        chk(u0_tb_oe == d && u0_ta_oe == !d, d ? "R4" : "R5", int'(u0_tb_oe), int'(d));
        for (int i = 0; i < n; i++) words[i] = gen(i, seed);
        for (int i = 0; i < n; i++) begin
            ent = (i == 0) || (mid_tok && i == 10);
            shift_one(words[i]);
            ent = 1'b0;
            if (i == 30) chk(!u0_ta_out && !u0_tb_out, "R6", int'(u0_ta_out | u0_tb_out), 0);
            if (i == 31) begin
                chk((d ? u0_tb_out : u0_ta_out) == 1'b1, "R6", int'(d ? u0_tb_out : u0_ta_out), 1);
                chk((d ? u0_ta_out : u0_tb_out) == 1'b0, d ? "R4" : "R5",
                    int'(d ? u0_ta_out : u0_tb_out), 0);
                cmp_row(c0, 0, "R3");
            end
            if (chain && i == 63)
                chk((d ? u1_tb_out : u1_ta_out) == 1'b1, "R9", int'(d ? u1_tb_out : u1_ta_out), 1);
        end
        // extra rising edge: exit pulse ends, nothing stored
        shift_one(7'h55);
        chk(!u0_ta_out && !u0_tb_out, "R6", int'(u0_ta_out | u0_tb_out), 0);
        // falling edge with token high while idle: ignored (R7)
        ent = 1'b1;
        shift_one(7'h2a);
        ent = 1'b0;
        repeat (2) @(negedge clk);
        cmp_row(c0, 0, "R8");
        chk(!u0_ta_out && !u0_tb_out, "R7", int'(u0_ta_out | u0_tb_out), 0);
        if (chain) cmp_row(c1, 32, "R9");
        chain_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: state while reset is held
        chk(c0 == '0, "R1", int'(c0[W-1:0]), 0);
        chk(!u0_ta_out && !u0_tb_out, "R1", int'(u0_ta_out | u0_tb_out), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(c0 == '0 && c1 == '0, "R1", int'(c0[W-1:0]), 0);
        chk(!u0_ta_out && !u0_tb_out, "R1", int'(u0_ta_out | u0_tb_out), 0);
        chk(u0_tb_oe == 1'b1 && u0_ta_oe == 1'b0, "R4", int'(u0_tb_oe), 1);

        for (int dd = 1; dd >= 0; dd--) begin
            fill_run(logic'(dd), 1, 1'b0, 1'b0);
            fill_run(logic'(dd), 37, 1'b1, 1'b0);   // R7: token mid-fill
            fill_run(logic'(dd), 0, 1'b0, 1'b0);
            fill_run(logic'(dd), 90, 1'b0, 1'b1);   // R9: chained pair
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule